// File: doc/BRIEF.md
# Register-Mapped Serial Port Core

A byte-wide asynchronous serial port behind a small 32-bit register bus. Software writes bytes into one data port, and they queue in a transmit FIFO. The transmitter sends each byte as a frame of one start bit, eight data bits with the least significant bit first, and one stop bit. Frames the receiver assembles on the line are queued in a receive FIFO. Software drains that FIFO by reading the same data port.

Bit timing comes from an external `baud_tick` strobe that runs at OVS times the bit rate. The divider and generator registers are plain storage. They are kept so that software writing them finds them at their usual places. A control register enables each direction on its own and holds per-direction soft-reset bits. Software may write the resets and the enables in one store. A status register reports whether the receive FIFO is empty, whether the transmit FIFO is full, a sticky framing error, and whether the transmitter is still busy on the line.

Top module: `serial_reg_core`

## Requirements
- R1: The mode register (offset 0x04, bits 10:0), the baud generator register (offset 0x18, bits 15:0) and the baud divider register (offset 0x34, bits 7:0) read back what was written, with their upper bits as 0. An unmapped offset such as 0x08 reads 0.
- R2: Control register (offset 0x00): bit 2 enables the receiver and bit 4 enables the transmitter, and both read back. Bit 0 (receive reset) and bit 1 (transmit reset) always read as 0.
- R3: After reset the status register (offset 0x2C) reads 0x002, the control register reads 0, and `txd` is 1.
- R4: Each transmit frame starts with a low start bit, then sends 8 data bits with the LSB first, then a high stop bit. Every bit lasts OVS baud ticks, and `txd` is 1 whenever no frame is in progress.
- R5: Status bit 11 is 1 while a frame is being shifted out, even when the transmit FIFO is empty. It returns to 0 once the stop bit has been sent.
- R6: The transmit FIFO holds DEPTH (16) bytes. Status bit 4 is 1 while it is full, and a data-port write (offset 0x30) while it is full is discarded.
- R7: Writing 1 to control bit 1 empties the transmit FIFO and stops the shifter, and the bit clears itself one cycle later. An enable written in the same store takes effect after the flush.
- R8: A received frame whose stop bit is high is queued. A data-port read returns the oldest queued byte and removes it. A read while the FIFO is empty returns 0. Status bit 1 is 1 while the receive FIFO is empty.
- R9: A received frame whose stop bit samples low is dropped and sets status bit 7. That bit stays set through later good frames until software writes 1 to status bit 7.
- R10: Writing 1 to control bit 0 empties the receive FIFO. A receiver enable written in the same store stays in force after the flush.
- R11: While the transmitter is disabled, queued bytes stay in the FIFO and `txd` stays high. While the receiver is disabled, frames on `rxd` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (6) | Byte offset of the register being accessed |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; a read of the data port removes one byte |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| baud_tick | input | 1 | Oversampling strobe at OVS times the bit rate |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |

## Verification
The hardest states to reach from the ports are the ones where a control store meets queued data. These are a transmit reset landing on a FIFO that a disabled transmitter has filled, and a receive reset landing on bytes nobody has read. The bench first parks bytes by clearing an enable. It then issues the combined reset-and-enable store and watches the line, so that nothing stale leaves it and a new byte still does. A frame with a low stop bit is driven straight after to reach the sticky error flag. The test then checks that the flag survives a good frame and clears only on the one-to-clear write.

// File: rtl/serial_reg_core.sv
module serial_reg_core #(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          baud_tick,
  input  logic          rxd,
  output logic          txd
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(OVS);
  localparam logic [PW:0]   FULL   = (PW+1)'(DEPTH);
  localparam logic [CW-1:0] T_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] T_MID  = CW'(OVS / 2 - 1);
  localparam logic [AW-1:0] A_CTRL = AW'('h00);
  localparam logic [AW-1:0] A_MODE = AW'('h04);
  localparam logic [AW-1:0] A_BGEN = AW'('h18);
  localparam logic [AW-1:0] A_STAT = AW'('h2C);
  localparam logic [AW-1:0] A_DATA = AW'('h30);
  localparam logic [AW-1:0] A_BDIV = AW'('h34);

  logic        tx_en, rx_en, tx_rst_q, rx_rst_q;
  logic [10:0] mode_q;
  logic [15:0] bgen_q;
  logic [7:0]  bdiv_q;

  logic [7:0]    txq [DEPTH];
  logic [7:0]    rxq [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [PW:0]   tx_cnt, rx_cnt;

  logic          tx_busy;
  logic [9:0]    tx_sh;
  logic [3:0]    tx_bits;
  logic [CW-1:0] tx_tk;

  logic          rx_s1, rx_s2, rx_s3, rx_act, ferr;
  logic [3:0]    rx_bits;
  logic [CW-1:0] rx_tk;
  logic [7:0]    rx_sh;

  wire wr_dat  = wr_en && addr == A_DATA;
  wire rd_dat  = rd_en && addr == A_DATA;
  wire tx_full = tx_cnt == FULL;
  wire rx_full = rx_cnt == FULL;
  wire rx_empty = rx_cnt == '0;
  wire tx_push = wr_dat && !tx_full;
  wire tx_pop  = tx_en && !tx_rst_q && !tx_busy && tx_cnt != '0;
  wire rx_pop  = rd_dat && !rx_empty;
  wire rx_mid  = rx_act && baud_tick && rx_tk == T_MID;
  wire rx_push = rx_mid && rx_bits == 4'd9 && rx_s2 && !rx_full && !rx_rst_q;
  wire ferr_clr = wr_en && addr == A_STAT && wdata[7];

  assign txd = tx_sh[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {tx_en, rx_en, tx_rst_q, rx_rst_q} <= '0;
      mode_q <= '0; bgen_q <= '0; bdiv_q <= '0;
    end else begin
      tx_rst_q <= 1'b0;
      rx_rst_q <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_CTRL: begin
            rx_rst_q <= wdata[0];
            tx_rst_q <= wdata[1];
            rx_en    <= wdata[2];
            tx_en    <= wdata[4];
          end
          A_MODE: mode_q <= wdata[10:0];
          A_BGEN: bgen_q <= wdata[15:0];
          A_BDIV: bdiv_q <= wdata[7:0];
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk) begin
    if (tx_push) txq[tx_wp] <= wdata[7:0];
    if (rx_push) rxq[rx_wp] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_rst_q) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (tx_push && !tx_pop) tx_cnt <= tx_cnt + 1'b1;
      else if (!tx_push && tx_pop) tx_cnt <= tx_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_rst_q) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      if (rx_push && !rx_pop) rx_cnt <= rx_cnt + 1'b1;
      else if (!rx_push && rx_pop) rx_cnt <= rx_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_bits <= '0; tx_tk <= '0;
    end else if (tx_rst_q) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_bits <= '0; tx_tk <= '0;
    end else if (tx_pop) begin
      tx_busy <= 1'b1;
      tx_sh   <= {1'b1, txq[tx_rp], 1'b0};
      tx_bits <= '0;
      tx_tk   <= '0;
    end else if (tx_busy && baud_tick) begin
      if (tx_tk == T_LAST) begin
        tx_tk <= '0;
        tx_sh <= {1'b1, tx_sh[9:1]};
        if (tx_bits == 4'd9) tx_busy <= 1'b0;
        else tx_bits <= tx_bits + 1'b1;
      end else
        tx_tk <= tx_tk + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {rx_s1, rx_s2, rx_s3} <= '1;
      rx_act <= 1'b0; rx_bits <= '0; rx_tk <= '0; rx_sh <= '0; ferr <= 1'b0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      rx_s3 <= rx_s2;
      if (ferr_clr) ferr <= 1'b0;
      if (rx_rst_q)
        rx_act <= 1'b0;
      else if (!rx_act) begin
        if (rx_en && baud_tick && rx_s3 && !rx_s2) begin
          rx_act <= 1'b1; rx_tk <= '0; rx_bits <= '0;
        end
      end else if (baud_tick) begin
        rx_tk <= (rx_tk == T_LAST) ? '0 : rx_tk + 1'b1;
        if (rx_tk == T_MID) begin
          rx_bits <= rx_bits + 1'b1;
          if (rx_bits == 4'd0) begin
            if (rx_s2) rx_act <= 1'b0;
          end else if (rx_bits == 4'd9) begin
            rx_act <= 1'b0;
            if (!rx_s2) ferr <= 1'b1;
          end else
            rx_sh <= {rx_s2, rx_sh[7:1]};
        end
      end
    end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin rdata[2] = rx_en; rdata[4] = tx_en; end
      A_MODE: rdata[10:0] = mode_q;
      A_BGEN: rdata[15:0] = bgen_q;
      A_BDIV: rdata[7:0]  = bdiv_q;
      A_STAT: begin
        rdata[1]  = rx_empty;
        rdata[4]  = tx_full;
        rdata[7]  = ferr;
        rdata[11] = tx_busy;
      end
      A_DATA: if (!rx_empty) rdata[7:0] = rxq[rx_rp];
      default: ;
    endcase
  end
endmodule

// File: rtl/serial_reg_core_chk.sv
module serial_reg_core_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [AW-1:0]            addr,
  input logic [31:0]              wdata,
  input logic [31:0]              rdata,
  input logic                     txd,
  input logic                     tx_busy,
  input logic                     tx_full,
  input logic                     tx_rst_q,
  input logic                     ferr,
  input logic [$clog2(DEPTH):0]   tx_cnt,
  input logic [$clog2(DEPTH):0]   rx_cnt
);
  localparam logic [AW-1:0] A_STAT = AW'('h2C);
  localparam logic [AW-1:0] A_DATA = AW'('h30);

  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= ($clog2(DEPTH)+1)'(DEPTH));

  p_full_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA && tx_full) |=> tx_cnt <= $past(tx_cnt));

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_q |=> (tx_cnt == '0 && !tx_busy));

  p_empty_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && addr == A_STAT) |-> rdata[1]);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr && !(wr_en && addr == A_STAT && wdata[7])) |=> ferr);
endmodule

bind serial_reg_core serial_reg_core_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .txd(txd), .tx_busy(tx_busy), .tx_full(tx_full),
  .tx_rst_q(tx_rst_q), .ferr(ferr), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/serial_reg_core_test.sv
module serial_reg_core_test;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, rxd = 1;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        txd;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] txexp[$];
  logic [7:0] rxexp[$];

  always #4 clk = ~clk;

  serial_reg_core uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .baud_tick(1'b1),
    .rxd(rxd), .txd(txd));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic send_tx(input logic [7:0] b, input bit expect_out);
    if (expect_out) txexp.push_back(b);
    wr(6'h30, {24'h0, b});
  endtask

  task automatic send_rx(input logic [7:0] b, input bit stop, input bit expect_in);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); rxd = 1;
    repeat (20) @(negedge clk);
    if (expect_in) rxexp.push_back(b);
  endtask

  task automatic drain_tx();
    for (int k = 0; k < 6000 && txexp.size() != 0; k++) @(negedge clk);
    check("R4 drain", 32'(txexp.size()), 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic drain_rx(string req);
    logic [31:0] d;
    while (rxexp.size() != 0) begin
      rd(6'h30, d);
      check(req, d, {24'h0, rxexp.pop_front()});
    end
  endtask

  initial begin : tx_monitor
    logic [7:0] b;
    forever begin
      @(negedge txd);
      repeat (8) @(negedge clk);
      check("R4 start", 32'(txd), 0);
      for (int i = 0; i < 8; i++) begin
        repeat (16) @(negedge clk);
        b[i] = txd;
      end
      repeat (16) @(negedge clk);
      check("R4 stop", 32'(txd), 1);
      if (txexp.size() == 0) check("R7 unexpected frame", {24'h0, b}, 32'hFFFF_FFFF);
      else check("R4 data", {24'h0, b}, {24'h0, txexp.pop_front()});
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(6'h2C, d); check("R3 status reset", d, 32'h002);
    rd(6'h00, d); check("R3 control reset", d, 0);
    check("R3 txd idle", 32'(txd), 1);
    rd(6'h08, d); check("R1 reserved", d, 0);

    wr(6'h04, 32'h20); rd(6'h04, d); check("R1 mode", d, 32'h20);
    wr(6'h18, 32'hABCD_1234); rd(6'h18, d); check("R1 baud gen", d, 32'h1234);
    wr(6'h34, 32'h3C5); rd(6'h34, d); check("R1 divider", d, 32'hC5);

    wr(6'h00, 32'h17); rd(6'h00, d); check("R2 control readback", d, 32'h14);

    send_tx(8'h55, 1);
    repeat (3) @(negedge clk);
    rd(6'h2C, d); check("R5 active with empty fifo", d & 32'h812, 32'h802);
    send_tx(8'hA3, 1); send_tx(8'h00, 1); send_tx(8'hFF, 1);
    drain_tx();
    rd(6'h2C, d); check("R5 idle after stop", d & 32'h800, 0);

    wr(6'h00, 32'h04);
    for (int i = 0; i < 16; i++) send_tx(8'h10 + 8'(i), 1);
    rd(6'h2C, d); check("R6 full flag", d & 32'h10, 32'h10);
    send_tx(8'hEE, 0);
    repeat (40) @(negedge clk);
    rd(6'h2C, d); check("R11 tx disabled idle", d & 32'h800, 0);
    check("R11 txd high", 32'(txd), 1);
    wr(6'h00, 32'h14);
    drain_tx();
    rd(6'h2C, d); check("R6 not full after drain", d & 32'h10, 0);

    wr(6'h00, 32'h04);
    send_tx(8'h61, 0); send_tx(8'h62, 0); send_tx(8'h63, 0);
    wr(6'h00, 32'h12);
    repeat (400) @(negedge clk);
    check("R7 flushed line idle", 32'(txd), 1);
    rd(6'h00, d); check("R7 reset bit reads 0", d, 32'h10);
    send_tx(8'h3C, 1);
    drain_tx();

    wr(6'h00, 32'h14);
    send_rx(8'h5A, 1, 1); send_rx(8'h81, 1, 1); send_rx(8'h00, 1, 1);
    rd(6'h2C, d); check("R8 not empty", d & 32'h2, 0);
    drain_rx("R8 rx data");
    rd(6'h30, d); check("R8 empty read", d, 0);
    rd(6'h2C, d); check("R8 empty flag", d & 32'h2, 32'h2);

    send_rx(8'h77, 0, 0);
    rd(6'h2C, d); check("R9 framing flag dropped", d & 32'h82, 32'h82);
    send_rx(8'h42, 1, 1);
    rd(6'h2C, d); check("R9 flag sticky", d & 32'h82, 32'h80);
    wr(6'h2C, 32'h80);
    rd(6'h2C, d); check("R9 flag cleared", d & 32'h80, 0);
    drain_rx("R9 good frame after error");

    send_rx(8'h11, 1, 0); send_rx(8'h22, 1, 0);
    wr(6'h00, 32'h15);
    rd(6'h2C, d); check("R10 flushed", d & 32'h2, 32'h2);
    rd(6'h30, d); check("R10 empty read", d, 0);
    send_rx(8'h33, 1, 1);
    drain_rx("R10 enable kept");

    wr(6'h00, 32'h10);
    send_rx(8'h99, 1, 0);
    rd(6'h2C, d); check("R11 rx disabled", d & 32'h2, 32'h2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule